// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block turns parallel characters into asynchronous serial frames. A character written at the write port goes into a one-entry holding buffer. When the shift register is free, the character moves into it and is shifted out on `txd`. A frame is a low start bit, then 5 to 9 data bits least significant first, then an optional even or odd parity bit, then one or two high stop bits. The line is high whenever no frame is being sent.

Bit timing comes from an external `baud_tick` strobe. A bit lasts 16 ticks, or 8 ticks in double-speed mode. Frame settings are taken when a character is moved into the shift register, so changing a setting never corrupts a frame that is already on the line. The ninth data bit has its own write strobe and must be written before the low bits.

Two status outputs let a host pace the block. `buf_empty` says that another character may be written. `tx_done` says that the line has finished and nothing is waiting to be sent. Dropping `tx_enable` stops new writes from being accepted, but the frame being shifted and the frame in the buffer are both still sent.

Top module: `serial_tx_hold`

## Requirements
- R1: After reset, `txd` is 1, `buf_empty` is 1 and `tx_done` is 0.
- R2: A frame is a start bit (0), then the data bits least significant first, then the optional parity bit, then the stop bits (1). The `cfg_size` code sets the data length: 000 gives 5 bits, 001 gives 6, 010 gives 7, 011 gives 8 and 111 gives 9. The codes 100, 101 and 110 give 8 bits.
- R3: The `cfg_parity` code selects the parity bit: 00 and 01 send no parity bit; 10 sends even parity (the data bits and the parity bit together hold an even number of ones); 11 sends odd parity.
- R4: When `cfg_two_stop` is 0 the frame ends with one stop bit; when it is 1 the frame ends with two.
- R5: Each bit lasts 16 `baud_tick` pulses when `cfg_double` is 0 and 8 pulses when it is 1.
- R6: The ninth data bit (bit 8 of the frame data) is the value last strobed in with `bit9_we`. That value is captured when the low bits are written. Changing it afterwards does not alter the buffered character.
- R7: A write (`wr_en` high while `tx_enable` is 1 and `buf_empty` is 1) fills the buffer: `buf_empty` is 0 in the next cycle. A write while the buffer is full is ignored and does not disturb the buffered character.
- R8: When the shift register is idle and the buffer is full, the character is loaded on the next `baud_tick` cycle. At that clock edge `buf_empty` rises and `txd` falls to the start bit together.
- R9: `tx_done` rises at the end of the last stop bit if the buffer is empty at that time, and falls in the cycle after an accepted write. While `tx_done` is 1, `buf_empty` and `txd` are both 1.
- R10: After `tx_enable` falls, the frame on the line and the frame in the buffer are both sent in full. Writes made while `tx_enable` is 0 are ignored: `buf_empty` stays 1 and no frame starts.
- R11: `txd` changes only at clock edges where `baud_tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the low data bits |
| wr_data | input | 8 | Low data bits of the character |
| bit9_we | input | 1 | Write strobe for the ninth data bit |
| bit9_in | input | 1 | Ninth data bit value |
| cfg_size | input | 3 | Character size code |
| cfg_parity | input | 2 | Parity mode code |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cfg_double | input | 1 | 1 selects 8 ticks per bit instead of 16 |
| tx_enable | input | 1 | Transmitter enable |
| baud_tick | input | 1 | Sub-bit timing strobe |
| txd | output | 1 | Serial output, idles high |
| buf_empty | output | 1 | Holding buffer can accept a character |
| tx_done | output | 1 | Line finished and nothing pending |

## Verification
The bench attacks the places where a transmitter with a buffer most often goes wrong:
- A character written while another is shifting: a design that overwrote the buffered character, or that took a write while the buffer was full, would put a wrong or extra frame on the line.
- The ninth bit changed after the low bits were written: a design that read the bit live instead of capturing it would send the new value.
- Frames in flight when `tx_enable` falls: a design that disabled at once would cut the last frame short.
- The reserved size and parity codes, two stop bits and double speed: a design that mishandled any of these would place bits at the wrong positions or for the wrong number of ticks, and the mid-bit samples would not match.

// File: rtl/serial_tx_hold.sv
module serial_tx_hold #(
  parameter int TICKS_SLOW = 16,
  parameter int TICKS_FAST = 8,
  parameter int MAX_DATA   = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [MAX_DATA-2:0] wr_data,
  input  logic                bit9_we,
  input  logic                bit9_in,
  input  logic [2:0]          cfg_size,
  input  logic [1:0]          cfg_parity,
  input  logic                cfg_two_stop,
  input  logic                cfg_double,
  input  logic                tx_enable,
  input  logic                baud_tick,
  output logic                txd,
  output logic                buf_empty,
  output logic                tx_done
);
  localparam int FRAME_W = MAX_DATA + 4;
  localparam int LEN_W   = $clog2(FRAME_W + 1);
  localparam int CNT_W   = $clog2(TICKS_SLOW);
  localparam logic [CNT_W-1:0] LAST_SLOW = CNT_W'(TICKS_SLOW - 1);
  localparam logic [CNT_W-1:0] LAST_FAST = CNT_W'(TICKS_FAST - 1);

  logic                bit9_q;
  logic                hold_full;
  logic [MAX_DATA-1:0] hold_q;
  logic [FRAME_W-1:0]  shift_q;
  logic [FRAME_W-1:0]  frame_d;
  logic [LEN_W-1:0]    left_q;
  logic [LEN_W-1:0]    len_d;
  logic [CNT_W-1:0]    tick_q;
  logic                fast_q;
  logic                par_bit;
  int                  ndata;

  wire busy     = (left_q != '0);
  wire take     = wr_en && tx_enable && !hold_full;
  wire load     = baud_tick && !busy && hold_full;
  wire bit_end  = baud_tick && busy && (tick_q == (fast_q ? LAST_FAST : LAST_SLOW));
  wire last_end = bit_end && (left_q == LEN_W'(1));

  always_comb begin
    case (cfg_size)
      3'b000:  ndata = 5;
      3'b001:  ndata = 6;
      3'b010:  ndata = 7;
      3'b111:  ndata = MAX_DATA;
      default: ndata = 8;
    endcase
    frame_d    = '1;
    frame_d[0] = 1'b0;
    par_bit    = cfg_parity[0];
    for (int i = 0; i < MAX_DATA; i++) begin
      if (i < ndata) begin
        frame_d[i+1] = hold_q[i];
        par_bit      = par_bit ^ hold_q[i];
      end
    end
    if (cfg_parity[1]) frame_d[ndata+1] = par_bit;
    len_d = LEN_W'(1 + ndata + (cfg_parity[1] ? 1 : 0) + (cfg_two_stop ? 2 : 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit9_q    <= 1'b0;
      hold_q    <= '0;
      hold_full <= 1'b0;
      shift_q   <= '1;
      left_q    <= '0;
      tick_q    <= '0;
      fast_q    <= 1'b0;
      tx_done   <= 1'b0;
    end else begin
      if (bit9_we) bit9_q <= bit9_in;

      if (take) begin
        hold_q    <= {bit9_q, wr_data};
        hold_full <= 1'b1;
      end else if (load) begin
        hold_full <= 1'b0;
      end

      if (load) begin
        shift_q <= frame_d;
        left_q  <= len_d;
        tick_q  <= '0;
        fast_q  <= cfg_double;
      end else if (bit_end) begin
        shift_q <= {1'b1, shift_q[FRAME_W-1:1]};
        left_q  <= left_q - LEN_W'(1);
        tick_q  <= '0;
      end else if (baud_tick && busy) begin
        tick_q  <= tick_q + CNT_W'(1);
      end

      if (take) tx_done <= 1'b0;
      else if (last_end && !hold_full) tx_done <= 1'b1;
    end
  end

  assign txd       = busy ? shift_q[0] : 1'b1;
  assign buf_empty = !hold_full;
endmodule

// File: rtl/serial_tx_hold_chk.sv
module serial_tx_hold_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic tx_enable,
  input logic baud_tick,
  input logic txd,
  input logic buf_empty,
  input logic tx_done
);
  a_r11_txd_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !baud_tick |=> $stable(txd));

  a_r8_empty_rises_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_empty) |-> $past(baud_tick));

  a_r7_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && tx_enable && buf_empty) |=> (!buf_empty && !tx_done));

  a_r7_full_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !buf_empty && !baud_tick) |=> !buf_empty);

  a_r10_disabled_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !tx_enable && buf_empty) |=> buf_empty);

  a_r9_done_means_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> (buf_empty && txd));
endmodule

bind serial_tx_hold serial_tx_hold_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .tx_enable(tx_enable),
  .baud_tick(baud_tick), .txd(txd), .buf_empty(buf_empty), .tx_done(tx_done)
);

// File: tb/sim_serial_tx_hold.sv
module sim_serial_tx_hold;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       bit9_we = 1'b0, bit9_in = 1'b0;
  logic [2:0] cfg_size = 3'b011;
  logic [1:0] cfg_parity = 2'b00;
  logic       cfg_two_stop = 1'b0, cfg_double = 1'b0, tx_enable = 1'b0, baud_tick = 1'b0;
  logic       txd, buf_empty, tx_done;

  serial_tx_hold u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .bit9_we(bit9_we), .bit9_in(bit9_in), .cfg_size(cfg_size),
    .cfg_parity(cfg_parity), .cfg_two_stop(cfg_two_stop),
    .cfg_double(cfg_double), .tx_enable(tx_enable), .baud_tick(baud_tick),
    .txd(txd), .buf_empty(buf_empty), .tx_done(tx_done)
  );

  typedef struct packed {
    logic [12:0] bits;
    logic [3:0]  len;
    logic [4:0]  nt;
  } frame_t;

  frame_t exp_q[$];
  int checks = 0, failures = 0, frames_seen = 0, r11_bad = 0;
  bit finished = 1'b0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic frame_t mk(logic b9, logic [7:0] d, logic [2:0] sz,
                                logic [1:0] par, logic two, logic dbl);
    frame_t f;
    logic [8:0] v;
    logic p;
    int n, pos;
    v = {b9, d};
    n = (sz == 3'b000) ? 5 : (sz == 3'b001) ? 6 : (sz == 3'b010) ? 7 :
        (sz == 3'b111) ? 9 : 8;
    f.bits = '1;
    f.bits[0] = 1'b0;
    p = 1'b0;
    for (int i = 0; i < n; i++) begin
      f.bits[i+1] = v[i];
      p = p ^ v[i];
    end
    pos = n + 1;
    if (par[1]) begin
      f.bits[pos] = p ^ par[0];
      pos++;
    end
    pos += two ? 2 : 1;
    f.len = 4'(pos);
    f.nt = dbl ? 5'd8 : 5'd16;
    return f;
  endfunction

  // baud tick every third cycle
  initial begin
    int tcnt = 0;
    forever begin
      @(negedge clk);
      tcnt = (tcnt + 1) % 3;
      baud_tick = (tcnt == 0);
    end
  end

  task automatic wait_ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (baud_tick !== 1'b1) @(posedge clk);
    end
  endtask

  // R11 observer: txd may only change after an edge that saw a tick
  logic tick_seen = 1'b0;
  logic last_txd = 1'b1;
  initial forever begin @(posedge clk); tick_seen = baud_tick; end
  initial forever begin
    @(negedge clk);
    if (rst_n && txd !== last_txd && !tick_seen) r11_bad++;
    last_txd = txd;
  end

  // monitor: pops expected frames and samples each bit at its middle
  initial begin
    forever begin
      frame_t f;
      logic [12:0] got;
      @(negedge clk);
      if (rst_n && txd === 1'b0) begin
        if (exp_q.size() == 0) begin
          check("R7/R10 unexpected frame", 1, 0);
          while (txd !== 1'b1) @(negedge clk);
        end else begin
          f = exp_q.pop_front();
          got = '1;
          for (int k = 0; k < int'(f.len); k++) begin
            wait_ticks(int'(f.nt) / 2);
            @(negedge clk);
            got[k] = txd;
            wait_ticks(int'(f.nt) - int'(f.nt) / 2);
          end
          check("R2/R3/R4/R5/R6 frame bits", 32'(got), 32'(f.bits));
          frames_seen++;
        end
      end
    end
  end

  // driver: strobe ninth bit, then write low bits; push expected on accept
  task automatic put(logic [7:0] d, logic b9, bit accept);
    @(negedge clk);
    bit9_we = 1'b1; bit9_in = b9;
    @(negedge clk);
    bit9_we = 1'b0;
    wr_data = d; wr_en = 1'b1;
    if (accept) exp_q.push_back(mk(b9, d, cfg_size, cfg_parity, cfg_two_stop, cfg_double));
    @(negedge clk);
    wr_en = 1'b0;
    if (accept) begin
      check("R7 buffer filled", 32'(buf_empty), 0);
      check("R9 done cleared by write", 32'(tx_done), 0);
    end
  endtask

  task automatic wait_done();
    do @(negedge clk); while (tx_done !== 1'b1);
    check("R9 done with idle line", 32'({buf_empty, txd}), 32'b11);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [2:0] sz_t [8] = '{3'b000, 3'b001, 3'b010, 3'b011, 3'b111, 3'b111, 3'b100, 3'b011};
    logic [1:0] pr_t [8] = '{2'b00, 2'b10, 2'b11, 2'b10, 2'b11, 2'b00, 2'b01, 2'b11};
    logic       st_t [8] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};
    logic [7:0] dt_t [8] = '{8'h15, 8'h2B, 8'h5A, 8'hC3, 8'h81, 8'h7E, 8'hE7, 8'h00};
    logic       b9_t [8] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
    int seen0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 txd idle", 32'(txd), 1);
    check("R1 buffer empty", 32'(buf_empty), 1);
    check("R1 done low", 32'(tx_done), 0);

    tx_enable = 1'b1;
    put(8'hA5, 1'b0, 1'b1);
    do @(negedge clk); while (buf_empty !== 1'b1);
    check("R8 load edge starts frame", 32'(txd), 0);
    wait_done();

    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      cfg_size = sz_t[k]; cfg_parity = pr_t[k]; cfg_two_stop = st_t[k];
      put(dt_t[k], b9_t[k], 1'b1);
      wait_done();
    end

    // R5: double speed, 8-bit and 9-bit with parity
    @(negedge clk);
    cfg_double = 1'b1; cfg_size = 3'b011; cfg_parity = 2'b00; cfg_two_stop = 1'b0;
    put(8'h55, 1'b0, 1'b1);
    wait_done();
    @(negedge clk);
    cfg_size = 3'b111; cfg_parity = 2'b10; cfg_two_stop = 1'b1;
    put(8'hF0, 1'b1, 1'b1);
    wait_done();
    @(negedge clk);
    cfg_double = 1'b0;

    // R6 / R7: buffer behind a busy shifter, late ninth-bit change, write when full
    put(8'h96, 1'b0, 1'b1);
    do @(negedge clk); while (buf_empty !== 1'b1);
    put(8'h3C, 1'b1, 1'b1);
    @(negedge clk);
    bit9_we = 1'b1; bit9_in = 1'b0;
    @(negedge clk);
    bit9_we = 1'b0;
    put(8'hFF, 1'b0, 1'b0);
    check("R7 full write ignored", 32'(buf_empty), 0);
    check("R9 done low while pending", 32'(tx_done), 0);
    wait_done();

    // R10: disable with one frame shifting and one buffered
    @(negedge clk);
    seen0 = frames_seen;
    cfg_size = 3'b011; cfg_parity = 2'b11; cfg_two_stop = 1'b0;
    put(8'h01, 1'b0, 1'b1);
    do @(negedge clk); while (buf_empty !== 1'b1);
    put(8'h80, 1'b0, 1'b1);
    tx_enable = 1'b0;
    do @(negedge clk); while (buf_empty !== 1'b1);
    put(8'h42, 1'b0, 1'b0);
    check("R10 disabled write ignored", 32'(buf_empty), 1);
    wait_done();
    repeat (20) @(negedge clk);
    check("R10 both pending frames sent", 32'(frames_seen - seen0), 2);

    repeat (400) @(negedge clk);
    check("R10 no stray frame after disable", 32'(txd), 1);
    check("R2 all expected frames seen", 32'(exp_q.size()), 0);
    check("R11 txd changed off tick", 32'(r11_bad), 0);

    if (!finished) begin
      finished = 1'b1;
      summary();
      $finish;
    end
  end
endmodule